// File: doc/BRIEF.md
# Word Atomic Memory Operation Unit

This block carries out 32-bit atomic memory operations on a memory port whose addresses are already physical. A request gives the 5-bit operation field taken from the instruction, the target address and the second source operand. For each request the unit performs the following steps in order:

- read the addressed word;
- form the new value in a small arithmetic and logic stage;
- write the new value back if the operation calls for it;
- return the destination-register value.

A one-entry reservation supports load-reserved and store-conditional. Encodings the unit does not support end in an illegal-instruction trap, and they touch no memory.

Requests enter on a valid/ready channel. `req_ready` is high only while the unit is idle, so a request waits, held stable by the sender, until the previous one has been answered. Results leave on a second valid/ready channel. While `rsp_valid` is high and `rsp_ready` is low, the unit holds the response and all its fields unchanged. It takes no new request until the response is consumed. The memory port is a plain synchronous single-port interface. Read data is due one cycle after a read strobe. A write is a single strobe with `mem_we` high.

Top module: `amo_unit`

## Requirements
- R1: `req_ready` is high exactly when the unit is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A pending response keeps `rsp_valid`, `rsp_data`, `rsp_trap` and `rsp_cause` stable until `rsp_ready` is high.
- R2: For every legal operation except store-conditional, `rsp_data` is the memory word as it was before the operation.
- R3: Writing operations and their funct5 codes are: add 00000 (old + src, modulo 2^32), swap 00001 (src), xor 00100, or 01000, and 01100. Each writes its result to the word it read.
- R4: Signed min 10000 and signed max 10100 compare as two's-complement 32-bit values. Unsigned min 11000 and unsigned max 11100 compare as unsigned values. Each writes the chosen value back.
- R5: Load-reserved (00010) performs no memory write. It records the word address (address bits above bit 1) in the reservation.
- R6: Store-conditional (00011) succeeds when the reservation is held and its word address equals the request's word address, ignoring address bits 1:0. On success it writes src and returns 0.
- R7: A failed store-conditional performs no write and returns 1. Every store-conditional, whether it succeeds or fails, clears the reservation.
- R8: Any funct5 not listed in R3 to R7 raises `rsp_trap` with `rsp_cause` = 2 and `rsp_data` = 0. Such a request makes no memory access, and its response is valid on the first cycle after acceptance.
- R9: Reset clears the reservation, so a store-conditional issued first after reset fails.
- R10: For a legal operation, `busy` is high on the three cycles after acceptance. In that window the memory read strobe comes first, the response follows on the fourth cycle, and `busy` and `rsp_valid` are never high together. Any write falls two cycles after the read, at the same word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_op | input | 5 | Operation field (funct5) |
| req_addr | input | AW | Physical byte address |
| req_src | input | XLEN | Second source operand |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | XLEN | Destination-register value |
| rsp_trap | output | 1 | Illegal-instruction trap |
| rsp_cause | output | 4 | Trap cause, 2 when trapping, else 0 |
| busy | output | 1 | Operation in flight, result not yet valid |
| mem_en | output | 1 | Memory strobe |
| mem_we | output | 1 | Strobe is a write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, one cycle after a read strobe |

## Verification
In the compare cycle of a store-conditional, the reservation is tested against the address and is also cleared. Load-reserved sets the reservation in that same compare stage. Both kinds of collision are provoked by chains such as load-reserved then two store-conditionals to the same word, and by a reservation taken on one word followed by a store-conditional on another. A correct result has the first store-conditional return 0 with one write, and every following one return 1 with zero writes and the memory word unchanged. Response back-pressure is applied throughout, so that each hold of a pending response overlaps the next request already waiting at the input.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam logic [4:0] F_ADD  = 5'b00000;
  localparam logic [4:0] F_SWAP = 5'b00001;
  localparam logic [4:0] F_LR   = 5'b00010;
  localparam logic [4:0] F_SC   = 5'b00011;
  localparam logic [4:0] F_XOR  = 5'b00100;
  localparam logic [4:0] F_OR   = 5'b01000;
  localparam logic [4:0] F_AND  = 5'b01100;
  localparam logic [4:0] F_MIN  = 5'b10000;
  localparam logic [4:0] F_MAX  = 5'b10100;
  localparam logic [4:0] F_MINU = 5'b11000;
  localparam logic [4:0] F_MAXU = 5'b11100;

  localparam logic [3:0] CAUSE_ILLEGAL = 4'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_CMP, ST_WR, ST_RSP
  } amo_state_e;

  function automatic logic op_legal(input logic [4:0] f);
    case (f)
      F_ADD, F_SWAP, F_LR, F_SC, F_XOR, F_OR, F_AND,
      F_MIN, F_MAX, F_MINU, F_MAXU: op_legal = 1'b1;
      default:                      op_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [4:0]      op,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] new_val
);
  logic s_lt;
  logic u_lt;

  assign s_lt = $signed(src_val) < $signed(old_val);
  assign u_lt = src_val < old_val;

  always_comb begin
    case (op)
      F_ADD:   new_val = old_val + src_val;
      F_SWAP:  new_val = src_val;
      F_SC:    new_val = src_val;
      F_XOR:   new_val = old_val ^ src_val;
      F_OR:    new_val = old_val | src_val;
      F_AND:   new_val = old_val & src_val;
      F_MIN:   new_val = s_lt ? src_val : old_val;
      F_MAX:   new_val = s_lt ? old_val : src_val;
      F_MINU:  new_val = u_lt ? src_val : old_val;
      F_MAXU:  new_val = u_lt ? old_val : src_val;
      default: new_val = old_val;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int WA = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [WA-1:0] addr_i,
  output logic          hit_o
);
  logic          held;
  logic [WA-1:0] tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      tag  <= '0;
    end else if (clr_i) begin
      held <= 1'b0;
    end else if (set_i) begin
      held <= 1'b1;
      tag  <= addr_i;
    end
  end

  assign hit_o = held && (tag == addr_i);

  // R7: any store-conditional leaves no reservation behind
  assert_sc_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !held);
  // R5: load-reserved arms the reservation on its own address
  assert_lr_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> held && tag == $past(addr_i));
endmodule

// File: rtl/amo_unit.sv
module amo_unit import amo_pkg::*; #(
  parameter int AW   = 26,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [4:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [XLEN-1:0] req_src,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [XLEN-1:0] rsp_data,
  output logic            rsp_trap,
  output logic [3:0]      rsp_cause,
  output logic            busy,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);
  localparam int WA = AW - 2;

  amo_state_e      state;
  logic [4:0]      op_q;
  logic [WA-1:0]   wa_q;
  logic [XLEN-1:0] src_q;
  logic [XLEN-1:0] new_q;
  logic [XLEN-1:0] rd_q;
  logic            wr_q;
  logic            trap_q;
  logic [XLEN-1:0] alu_new;
  logic            resv_hit;
  logic            in_cmp;
  logic            is_lr;
  logic            is_sc;

  assign in_cmp = (state == ST_CMP);
  assign is_lr  = (op_q == F_LR);
  assign is_sc  = (op_q == F_SC);

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op(op_q), .old_val(mem_rdata), .src_val(src_q), .new_val(alu_new)
  );

  amo_resv #(.WA(WA)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .set_i(in_cmp && is_lr), .clr_i(in_cmp && is_sc),
    .addr_i(wa_q), .hit_o(resv_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      wa_q   <= '0;
      src_q  <= '0;
      new_q  <= '0;
      rd_q   <= '0;
      wr_q   <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          op_q   <= req_op;
          wa_q   <= req_addr[AW-1:2];
          src_q  <= req_src;
          wr_q   <= 1'b0;
          rd_q   <= '0;
          trap_q <= !op_legal(req_op);
          state  <= op_legal(req_op) ? ST_RD : ST_RSP;
        end
        ST_RD:   state <= ST_CMP;
        ST_CMP: begin
          new_q <= alu_new;
          rd_q  <= is_sc ? {{(XLEN-1){1'b0}}, !resv_hit} : mem_rdata;
          wr_q  <= !is_lr && (!is_sc || resv_hit);
          state <= ST_WR;
        end
        ST_WR:   state <= ST_RSP;
        ST_RSP:  if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state == ST_RD) || (state == ST_CMP) || (state == ST_WR);
  assign rsp_valid = (state == ST_RSP);
  assign rsp_data  = rd_q;
  assign rsp_trap  = trap_q;
  assign rsp_cause = trap_q ? CAUSE_ILLEGAL : 4'd0;
  assign mem_en    = (state == ST_RD) || ((state == ST_WR) && wr_q);
  assign mem_we    = (state == ST_WR) && wr_q;
  assign mem_addr  = {wa_q, 2'b00};
  assign mem_wdata = new_q;

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rsp_valid);
  assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_en, 2) && !$past(mem_we, 2) && mem_addr == $past(mem_addr, 2));
  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_trap));
  assert_trap_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap) |-> !$past(mem_en) && rsp_data == '0);
  assert_minu_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmp && op_q == F_MINU) |-> alu_new <= mem_rdata && alu_new <= src_q);
  assert_maxu_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmp && op_q == F_MAXU) |-> alu_new >= mem_rdata && alu_new >= src_q);
  assert_lr_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmp && is_lr) |=> !wr_q);
endmodule

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
  import amo_pkg::*;
  localparam int AW = 26;
  localparam int XLEN = 32;

  typedef struct {
    logic [4:0]      op;
    int              idx;
    logic [XLEN-1:0] exp_rd;
    logic            exp_trap;
    logic [XLEN-1:0] exp_word;
    int              exp_wr;
    int              exp_rd_acc;
    int              exp_lat;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [4:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [XLEN-1:0] req_src = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [XLEN-1:0] rsp_data;
  logic rsp_trap;
  logic [3:0] rsp_cause;
  logic busy;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [XLEN-1:0] mem_wdata;
  logic [XLEN-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  amo_unit #(.AW(AW), .XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_src(req_src),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_trap(rsp_trap), .rsp_cause(rsp_cause), .busy(busy),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [XLEN-1:0] mem [64];
  logic [XLEN-1:0] ref_mem [64];
  logic            ref_rv = 1'b0;
  logic [AW-3:0]   ref_ra = '0;
  item_t           q[$];
  int checks = 0, fails = 0, cyc = 0, bp = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:2]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bp  <= bp + 1;
    #1 rsp_ready = (bp % 3) != 1;
  end

  task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: latency, access counts, busy, back-pressure hold, scoreboard
  int lat = 0, wr_cnt = 0, rd_cnt = 0;
  bit pend = 0, held = 0;
  logic [XLEN-1:0] held_data;
  logic held_trap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check(rsp_valid && rsp_data == held_data && rsp_trap == held_trap,
              "R1 hold", rsp_data, held_data);
        held = 0;
      end
      if (pend) begin
        lat++;
        if (mem_en && mem_we) wr_cnt++;
        if (mem_en && !mem_we) rd_cnt++;
        if (!rsp_valid && !busy) check(0, "R10 busy", 0, 1);
        if (rsp_valid && busy) check(0, "R10 excl", 1, 0);
        if (rsp_valid) begin
          item_t it;
          it = q.pop_front();
          check(rsp_data == it.exp_rd, $sformatf("R2/R6/R7 rd op=%b", it.op), rsp_data, it.exp_rd);
          check(rsp_trap == it.exp_trap && rsp_cause == (it.exp_trap ? 4'd2 : 4'd0),
                "R8 trap", {rsp_trap, rsp_cause}, {it.exp_trap, it.exp_trap ? 4'd2 : 4'd0});
          check(mem[it.idx] == it.exp_word, $sformatf("R3/R4 word op=%b", it.op), mem[it.idx], it.exp_word);
          check(wr_cnt == it.exp_wr, "R5/R7 writes", wr_cnt, it.exp_wr);
          check(rd_cnt == it.exp_rd_acc, "R8 reads", rd_cnt, it.exp_rd_acc);
          check(lat == it.exp_lat, "R10 latency", lat, it.exp_lat);
          pend = 0;
        end
      end
      if (rsp_valid && !rsp_ready) begin
        held = 1; held_data = rsp_data; held_trap = rsp_trap;
      end
      if (req_valid && req_ready) begin
        pend = 1; lat = 0; wr_cnt = 0; rd_cnt = 0;
      end
    end
  end

  task automatic do_op(input logic [4:0] op, input int byte_addr, input logic [XLEN-1:0] src);
    item_t it;
    int idx;
    logic [XLEN-1:0] old, nv;
    logic [AW-3:0] wa;
    logic ok;
    idx = (byte_addr >> 2) & 63;
    wa = byte_addr[AW-1:2];
    old = ref_mem[idx];
    nv = old;
    it.op = op; it.idx = idx; it.exp_trap = 0; it.exp_rd = old;
    it.exp_wr = 1; it.exp_rd_acc = 1; it.exp_lat = 4;
    case (op)
      F_ADD:  nv = old + src;
      F_SWAP: nv = src;
      F_XOR:  nv = old ^ src;
      F_OR:   nv = old | src;
      F_AND:  nv = old & src;
      F_MIN:  nv = ($signed(src) < $signed(old)) ? src : old;
      F_MAX:  nv = ($signed(src) > $signed(old)) ? src : old;
      F_MINU: nv = (src < old) ? src : old;
      F_MAXU: nv = (src > old) ? src : old;
      F_LR: begin it.exp_wr = 0; ref_rv = 1; ref_ra = wa; end
      F_SC: begin
        ok = ref_rv && ref_ra == wa;
        ref_rv = 0;
        it.exp_rd = ok ? 0 : 1;
        it.exp_wr = ok ? 1 : 0;
        if (ok) nv = src;
      end
      default: begin
        it.exp_trap = 1; it.exp_rd = 0; it.exp_wr = 0; it.exp_rd_acc = 0; it.exp_lat = 1;
      end
    endcase
    ref_mem[idx] = nv;
    it.exp_word = nv;
    q.push_back(it);
    @(posedge clk); #1;
    req_valid = 1; req_op = op; req_addr = AW'(byte_addr); req_src = src;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = i * 32'h0102_0304 + 32'h77;
      ref_mem[i] = mem[i];
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 reset ready", req_ready, 1);
    check(rsp_valid === 1'b0 && busy === 1'b0, "R10 reset idle", {rsp_valid, busy}, 0);
    check(mem_en === 1'b0, "R10 reset mem", mem_en, 0);
    do_op(F_SC, 4*3, 32'd55);                 // R9
    do_op(F_ADD, 4*1, 32'h10);                // R3
    do_op(F_ADD, 4*1, 32'hFFFF_FFFF);         // R3 wrap
    do_op(F_SWAP, 4*2, 32'h8000_0001);
    do_op(F_XOR, 4*4, 32'hA5A5_5A5A);
    do_op(F_OR, 4*4, 32'h0F00_00F0);
    do_op(F_AND, 4*4, 32'hF0F0_FF00);
    do_op(F_MIN, 4*2, 32'd5);                 // R4 negative old kept
    do_op(F_MAX, 4*2, 32'd5);
    do_op(F_SWAP, 4*5, 32'hFFFF_FFF0);
    do_op(F_MINU, 4*5, 32'd3);
    do_op(F_MAXU, 4*5, 32'hFFFF_FFFF);
    do_op(F_SWAP, 4*6, 32'hFFFF_FFFE);
    do_op(F_MIN, 4*6, 32'd1);
    do_op(F_MAXU, 4*6, 32'd1);
    do_op(F_MINU, 4*6, 32'd1);
    do_op(F_LR, 4*7, 32'd9);                  // R5
    do_op(F_SC, 4*7, 32'h1234_5678);          // R6 success
    do_op(F_SC, 4*7, 32'h0BAD_0BAD);          // R7 cleared
    do_op(F_LR, 4*8, 32'd0);
    do_op(F_SC, 4*9, 32'd1);                  // R7 wrong word
    do_op(F_SC, 4*8, 32'd2);                  // R7 cleared by failure
    do_op(F_LR, 4*10, 32'd0);
    do_op(F_LR, 4*11, 32'd0);
    do_op(F_SC, 4*11, 32'hCAFE_0011);         // R6 latest reservation
    do_op(F_LR, 4*12 + 2, 32'd0);
    do_op(F_SC, 4*12, 32'hBEEF_0012);         // R6 byte offset ignored
    do_op(5'b00101, 4*13, 32'd1);             // R8
    do_op(5'b11111, 4*13, 32'd1);
    do_op(5'b00110, 4*13, 32'd1);
    for (int i = 0; i < 40; i++) begin
      logic [4:0] ops [12];
      ops = '{F_ADD, F_SWAP, F_LR, F_SC, F_XOR, F_OR, F_AND,
              F_MIN, F_MAX, F_MINU, F_MAXU, 5'b10001};
      do_op(ops[(i * 7 + 3) % 12], 4 * (20 + (i % 5)), i * 32'h9E37_79B9);
    end
    repeat (10) @(posedge clk);
    check(q.size() == 0, "R1 drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule